// File: doc/BRIEF.md
# I2C Byte Command Sequencer

This block sits between a register file and a bit-level two-wire bus controller. Each command arrives as a one-clock-wide command word. The sequencer captures the word in that cycle. It then works through the requested steps in a fixed order: an optional START condition, one data byte written or read, the acknowledge bit, and an optional STOP condition. For each step it sends one request to the bit controller and waits for that controller's done strobe before it moves on.

On a write, the transmit byte goes out one bit per request, most significant bit first. The sequencer then samples the slave's acknowledge bit. On a read, the sequencer assembles the incoming bits into a byte and then drives the acknowledge value that the command selected. Software polls the status outputs: transfer in progress, the received acknowledge, the interrupt flag and arbitration loss. A START, a byte write and a STOP can all be requested in one command word.

Top module: `i2c_byte_seq`

## Requirements
- R1: The command word has these bit positions: bit 7 START, bit 6 STOP, bit 5 READ, bit 4 WRITE, bit 3 the acknowledge value for a read, bit 0 interrupt clear. A word is accepted only when all of these hold: the sequencer is idle, `core_en` is high, and at least one of bits 7..4 is set. A word that arrives while a command is running has no effect on the request stream.
- R2: Steps run in the order START, data byte, acknowledge, STOP. A step runs only if its bit is set; the acknowledge step belongs to the data byte. When WRITE and READ are both set, WRITE wins. The bit-controller op codes are START=0, STOP=1, WRITE=2, READ=3. Each request is one cycle wide. The next request is issued only after `bc_done` for the previous one.
- R3: `tip` goes high in the cycle after a command is accepted. It stays high until the cycle after the `bc_done` of the last step, then falls.
- R4: A write issues 8 WRITE requests that carry `tx_byte` most significant bit first. It then issues one READ request with `bc_dout`=1. The `bc_din` value at that request's done goes into `rx_ack` (0 = acknowledged, 1 = not acknowledged or no slave).
- R5: A read issues 8 READ requests with `bc_dout`=1 and assembles `bc_din` most significant bit first. `rx_byte` changes only after the eighth bit. The read then issues one WRITE request whose `bc_dout` is command bit 3.
- R6: `bc_arb_lost` during a command returns the sequencer to idle. In the next cycle `tip` is low and `al` is high, and no further request follows. `al` clears when the next command is accepted.
- R7: `irq_flag` is set when a command completes or arbitration is lost. A command word with bit 0 set clears it while `core_en` is high; a set in the same cycle wins over the clear. `irq` is `irq_flag` AND `int_en`.
- R8: While `core_en` is low, the sequencer stays idle and issues no request. All command words are ignored, including the interrupt clear.
- R9: After reset, `tip`, `al`, `irq_flag`, `rx_ack`, `rx_byte` and `bc_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_en | input | 1 | Core enable |
| int_en | input | 1 | Interrupt output enable |
| cmd_pulse | input | 8 | One-cycle command word |
| tx_byte | input | DATA_W | Byte to transmit |
| bc_req | output | 1 | One-cycle request to the bit controller |
| bc_op | output | 2 | Requested bit operation |
| bc_dout | output | 1 | Bit value to drive for a WRITE op |
| bc_done | input | 1 | Bit controller finished the current op |
| bc_din | input | 1 | Bit sampled from the bus by the last op |
| bc_arb_lost | input | 1 | Bit controller lost arbitration |
| rx_byte | output | DATA_W | Last byte received |
| rx_ack | output | 1 | Acknowledge returned by the slave |
| tip | output | 1 | Transfer in progress |
| al | output | 1 | Arbitration lost |
| irq_flag | output | 1 | Interrupt flag |
| irq | output | 1 | Gated interrupt |

## Verification
Most internal faults show up at the bit-controller port within one request. A wrong step order, a bad priority decode or a slipped bit counter produces a wrong `bc_op` or `bc_dout`, or a missing or extra request, on the very next `bc_req`. A fault in the completion or abort path shows up one cycle after the triggering `bc_done` or `bc_arb_lost`, as a `tip`, `al` or `irq_flag` that disagrees with the model. A fault in the receive path appears on `rx_byte` or `rx_ack` in the cycle after the eighth data bit or the acknowledge bit completes. It can also appear earlier, if a partial byte leaks out.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

   localparam int CMD_W   = 8;
   localparam int CB_STA  = 7;
   localparam int CB_STO  = 6;
   localparam int CB_RD   = 5;
   localparam int CB_WR   = 4;
   localparam int CB_ACK  = 3;
   localparam int CB_IACK = 0;

   typedef enum logic [1:0] {
      BOP_START = 2'd0,
      BOP_STOP  = 2'd1,
      BOP_WRITE = 2'd2,
      BOP_READ  = 2'd3
   } bop_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_START,
      SQ_DATA,
      SQ_ACK,
      SQ_STOP
   } sq_state_e;

   typedef struct packed {
      logic sto;
      logic rd;
      logic wr;
      logic ack;
   } cmd_t;

endpackage

// File: rtl/i2c_seq_cmd.sv
module i2c_seq_cmd
   import i2c_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             core_en,
   input  logic             idle,
   input  logic [CMD_W-1:0] cmd_pulse,
   output logic             accept,
   output logic             iack,
   output logic             sta_now,
   output cmd_t             now_cmd,
   output cmd_t             held_cmd
);

   logic unused_rsvd;
   assign unused_rsvd = ^cmd_pulse[2:1];

   always_comb begin
      sta_now     = cmd_pulse[CB_STA];
      now_cmd.wr  = cmd_pulse[CB_WR];
      now_cmd.rd  = cmd_pulse[CB_RD] & ~cmd_pulse[CB_WR];
      now_cmd.sto = cmd_pulse[CB_STO];
      now_cmd.ack = cmd_pulse[CB_ACK];
   end

   assign accept = core_en & idle &
                   (sta_now | now_cmd.wr | now_cmd.rd | now_cmd.sto);
   assign iack   = core_en & cmd_pulse[CB_IACK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held_cmd <= '0;
      else if (accept) held_cmd <= now_cmd;
   end

endmodule

// File: rtl/i2c_seq_shift.sv
module i2c_seq_shift #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              shift_en,
   input  logic              din,
   output logic              dout,
   output logic              last_bit,
   output logic [DATA_W-1:0] word_next
);

   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sreg;
   logic [CNT_W-1:0]  cnt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign dout      = sreg[DATA_W-1];
         assign word_next = {sreg[DATA_W-2:0], din};
      end else begin : g_lsb
         assign dout      = sreg[0];
         assign word_next = {din, sreg[DATA_W-1:1]};
      end
   endgenerate

   assign last_bit = (cnt == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         cnt  <= '0;
      end else if (load) begin
         sreg <= load_val;
         cnt  <= '0;
      end else if (shift_en) begin
         sreg <= word_next;
         cnt  <= last_bit ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/i2c_seq_status.sv
module i2c_seq_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              cmd_done,
   input  logic              arb_hit,
   input  logic              iack,
   input  logic              ack_smp,
   input  logic              ack_val,
   input  logic              rx_load,
   input  logic [DATA_W-1:0] rx_val,
   input  logic              int_en,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_ack,
   output logic              al,
   output logic              irq_flag,
   output logic              irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_byte  <= '0;
         rx_ack   <= 1'b0;
         al       <= 1'b0;
         irq_flag <= 1'b0;
      end else begin
         if (rx_load) rx_byte <= rx_val;
         if (ack_smp) rx_ack  <= ack_val;
         if (arb_hit)     al <= 1'b1;
         else if (accept) al <= 1'b0;
         if (cmd_done || arb_hit) irq_flag <= 1'b1;
         else if (iack)           irq_flag <= 1'b0;
      end
   end

   assign irq = irq_flag & int_en;

endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
   import i2c_seq_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_en,
   input  logic              int_en,
   input  logic [CMD_W-1:0]  cmd_pulse,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              bc_req,
   output logic [1:0]        bc_op,
   output logic              bc_dout,
   input  logic              bc_done,
   input  logic              bc_din,
   input  logic              bc_arb_lost,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_ack,
   output logic              tip,
   output logic              al,
   output logic              irq_flag,
   output logic              irq
);

   initial begin
      assert (DATA_W >= 2) else $fatal(1, "DATA_W must be at least 2");
   end

   sq_state_e         state_q, state_nxt, launch;
   logic              issue_q;
   logic              idle, accept, iack, sta_now;
   cmd_t              now_cmd, held_cmd;
   logic              step_done, arb_hit, cmd_done;
   logic              shift_en, last_bit, dbit, ack_smp, rx_load;
   logic [DATA_W-1:0] word_next;

   assign idle = (state_q == SQ_IDLE);

   i2c_seq_cmd u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .core_en  (core_en),
      .idle     (idle),
      .cmd_pulse(cmd_pulse),
      .accept   (accept),
      .iack     (iack),
      .sta_now  (sta_now),
      .now_cmd  (now_cmd),
      .held_cmd (held_cmd)
   );

   assign step_done = bc_done & ~issue_q & ~idle;
   assign arb_hit   = bc_arb_lost & ~idle & core_en;

   always_comb begin
      if (sta_now)                     launch = SQ_START;
      else if (now_cmd.wr | now_cmd.rd) launch = SQ_DATA;
      else                             launch = SQ_STOP;
   end

   always_comb begin
      state_nxt = state_q;
      unique case (state_q)
         SQ_START: begin
            if (held_cmd.wr | held_cmd.rd) state_nxt = SQ_DATA;
            else if (held_cmd.sto)         state_nxt = SQ_STOP;
            else                           state_nxt = SQ_IDLE;
         end
         SQ_DATA:  state_nxt = last_bit ? SQ_ACK : SQ_DATA;
         SQ_ACK:   state_nxt = held_cmd.sto ? SQ_STOP : SQ_IDLE;
         SQ_STOP:  state_nxt = SQ_IDLE;
         default:  state_nxt = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         issue_q <= 1'b0;
         tip     <= 1'b0;
      end else if (!core_en || arb_hit) begin
         state_q <= SQ_IDLE;
         issue_q <= 1'b0;
         tip     <= 1'b0;
      end else if (accept) begin
         state_q <= launch;
         issue_q <= 1'b1;
         tip     <= 1'b1;
      end else if (step_done) begin
         state_q <= state_nxt;
         issue_q <= (state_nxt != SQ_IDLE);
         tip     <= (state_nxt != SQ_IDLE);
      end else begin
         issue_q <= 1'b0;
      end
   end

   assign cmd_done = step_done & core_en & ~arb_hit & (state_nxt == SQ_IDLE);
   assign shift_en = step_done & core_en & ~arb_hit & (state_q == SQ_DATA);
   assign ack_smp  = step_done & core_en & ~arb_hit & (state_q == SQ_ACK) & held_cmd.wr;
   assign rx_load  = shift_en & last_bit & held_cmd.rd;

   i2c_seq_shift #(
      .DATA_W   (DATA_W),
      .MSB_FIRST(MSB_FIRST)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (tx_byte),
      .shift_en (shift_en),
      .din      (bc_din),
      .dout     (dbit),
      .last_bit (last_bit),
      .word_next(word_next)
   );

   assign bc_req = issue_q;

   always_comb begin
      bc_op   = BOP_START;
      bc_dout = 1'b1;
      unique case (state_q)
         SQ_START: bc_op = BOP_START;
         SQ_STOP:  bc_op = BOP_STOP;
         SQ_DATA: begin
            bc_op   = held_cmd.wr ? BOP_WRITE : BOP_READ;
            bc_dout = held_cmd.wr ? dbit : 1'b1;
         end
         SQ_ACK: begin
            bc_op   = held_cmd.wr ? BOP_READ : BOP_WRITE;
            bc_dout = held_cmd.wr ? 1'b1 : held_cmd.ack;
         end
         default: bc_op = BOP_START;
      endcase
   end

   i2c_seq_status #(
      .DATA_W(DATA_W)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .cmd_done(cmd_done),
      .arb_hit (arb_hit),
      .iack    (iack),
      .ack_smp (ack_smp),
      .ack_val (bc_din),
      .rx_load (rx_load),
      .rx_val  (word_next),
      .int_en  (int_en),
      .rx_byte (rx_byte),
      .rx_ack  (rx_ack),
      .al      (al),
      .irq_flag(irq_flag),
      .irq     (irq)
   );

endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       core_en,
   input logic [3:0] cmd_go,
   input logic       bc_req,
   input logic       bc_arb_lost,
   input logic       tip,
   input logic       al,
   input logic       irq_flag
);

   // R2: every request to the bit controller is a single-cycle strobe
   assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bc_req |=> !bc_req);

   // R3: an accepted command raises tip on the next cycle
   assert_tip_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (core_en && !tip && (|cmd_go)) |=> tip);

   // R6: arbitration loss ends the command with al set and no request
   assert_arb_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_arb_lost && tip && core_en) |=> (al && !tip && !bc_req));

   // R7: a command that ends while enabled leaves the interrupt flag set
   assert_end_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(tip) && $past(core_en)) |-> irq_flag);

   // R8: a disabled core issues no request on the following cycle
   assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !core_en |=> !bc_req);

endmodule

bind i2c_byte_seq i2c_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .core_en    (core_en),
   .cmd_go     (cmd_pulse[7:4]),
   .bc_req     (bc_req),
   .bc_arb_lost(bc_arb_lost),
   .tip        (tip),
   .al         (al),
   .irq_flag   (irq_flag)
);

// File: tb/i2c_byte_seq_tb.sv
module i2c_byte_seq_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       core_en = 1'b0;
   logic       int_en = 1'b0;
   logic [7:0] cmd_pulse = '0;
   logic [7:0] tx_byte = '0;
   logic       bc_req;
   logic [1:0] bc_op;
   logic       bc_dout;
   logic       bc_done = 1'b0;
   logic       bc_din = 1'b0;
   logic       bc_arb_lost = 1'b0;
   logic [7:0] rx_byte;
   logic       rx_ack, tip, al, irq_flag, irq;

   always #10 clk = ~clk;

   i2c_byte_seq u_dut (
      .clk(clk), .rst_n(rst_n), .core_en(core_en), .int_en(int_en),
      .cmd_pulse(cmd_pulse), .tx_byte(tx_byte),
      .bc_req(bc_req), .bc_op(bc_op), .bc_dout(bc_dout),
      .bc_done(bc_done), .bc_din(bc_din), .bc_arb_lost(bc_arb_lost),
      .rx_byte(rx_byte), .rx_ack(rx_ack), .tip(tip), .al(al),
      .irq_flag(irq_flag), .irq(irq)
   );

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   bit    exp_tip, exp_al, exp_if, exp_ack;
   int    exp_rx;
   int    q_op[$], q_dv[$], q_resp[$], q_rxc[$], q_ackc[$];
   string q_tag[$];
   int    cnt, cur_resp, cur_rxc, cur_ackc;
   bit    p_accept, p_done, p_final, p_arb, p_iack;
   int    p_rxc, p_ackc;
   // stimulus for the next cycle
   logic [7:0] cmd_now, tx_now, sd_now;
   bit         sack_now, arb_now;
   int         dly_now = 1;

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
      end
   endtask

   function automatic void push_op(input int op, input int dv, input string tg,
                                   input int rs, input int rxc, input int ackc);
      q_op.push_back(op); q_dv.push_back(dv); q_tag.push_back(tg);
      q_resp.push_back(rs); q_rxc.push_back(rxc); q_ackc.push_back(ackc);
   endfunction

   // expected request stream from the requirements (R2, R4, R5)
   function automatic void build(input logic [7:0] c, input logic [7:0] tx,
                                 input logic [7:0] sd, input bit sack);
      bit wr = c[4];
      bit rd = c[5] && !c[4];
      if (c[7]) push_op(0, -1, "R2", 0, -1, -1);
      if (wr) begin
         for (int i = 7; i >= 0; i--) push_op(2, tx[i], "R4", 0, -1, -1);
         push_op(3, 1, "R4", sack, -1, sack);
      end else if (rd) begin
         for (int i = 7; i >= 0; i--)
            push_op(3, 1, "R5", sd[i], (i == 0) ? int'(sd) : -1, -1);
         push_op(2, c[3], "R5", 0, -1, -1);
      end
      if (c[6]) push_op(1, -1, "R2", 0, -1, -1);
   endfunction

   task automatic cyc();
      @(negedge clk);
      // consequences of the inputs applied in the previous cycle
      if (p_accept) begin exp_tip = 1; exp_al = 0; end
      if (p_done) begin
         if (p_rxc >= 0)  exp_rx  = p_rxc;
         if (p_ackc >= 0) exp_ack = p_ackc[0];
         if (p_final) begin exp_tip = 0; exp_if = 1; end
      end
      if (p_arb) begin exp_tip = 0; exp_al = 1; exp_if = 1; end
      if (p_iack && !(p_done && p_final) && !p_arb) exp_if = 0;
      // per-cycle comparison
      chk(tip == exp_tip, "R3", "tip", tip, exp_tip);
      chk(al == exp_al, "R6", "al", al, exp_al);
      chk(irq_flag == exp_if, "R7", "irq_flag", irq_flag, exp_if);
      chk(irq == (exp_if && int_en), "R7", "irq", irq, exp_if && int_en);
      chk(rx_byte == exp_rx[7:0], "R5", "rx_byte", rx_byte, exp_rx);
      chk(rx_ack == exp_ack, "R4", "rx_ack", rx_ack, exp_ack);
      // behavioural bit controller
      bc_done = 0; p_done = 0; p_final = 0; p_rxc = -1; p_ackc = -1;
      if (bc_req) begin
         if (q_op.size() == 0) begin
            chk(0, "R1", "unexpected request op", bc_op, -1);
         end else begin
            int    o  = q_op.pop_front();
            int    d  = q_dv.pop_front();
            string tg = q_tag.pop_front();
            cur_resp = q_resp.pop_front();
            cur_rxc  = q_rxc.pop_front();
            cur_ackc = q_ackc.pop_front();
            chk(bc_op == o[1:0], "R2", "bc_op", bc_op, o);
            if (d >= 0) chk(bc_dout == d[0], tg, "bc_dout", bc_dout, d);
            cnt = dly_now;
         end
      end else if (cnt > 0) begin
         cnt--;
         if (cnt == 0) begin
            bc_done = 1; bc_din = cur_resp[0];
            p_done = 1; p_final = (q_op.size() == 0);
            p_rxc = cur_rxc; p_ackc = cur_ackc;
         end
      end
      // stimulus
      cmd_pulse   = cmd_now;
      tx_byte     = tx_now;
      bc_arb_lost = arb_now;
      p_arb    = arb_now && exp_tip && core_en;
      p_accept = core_en && !exp_tip && (|cmd_now[7:4]) && !p_arb;
      p_iack   = core_en && cmd_now[0];
      if (p_arb) begin
         q_op.delete(); q_dv.delete(); q_tag.delete();
         q_resp.delete(); q_rxc.delete(); q_ackc.delete();
         cnt = 0; bc_done = 0; p_done = 0; p_final = 0;
      end
      if (p_accept) build(cmd_now, tx_now, sd_now, sack_now);
      cmd_now = '0;
      arb_now = 0;
   endtask

   task automatic send(input logic [7:0] c, input logic [7:0] tx,
                       input logic [7:0] sd, input bit sack, input int dly);
      cmd_now = c; tx_now = tx; sd_now = sd; sack_now = sack; dly_now = dly;
      cyc();
      cyc();
      for (int i = 0; i < 400 && exp_tip; i++) cyc();
      chk(!exp_tip && q_op.size() == 0, "R3", "command finished", tip, 0);
      cyc();
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      cmd_now = '0; tx_now = '0; sd_now = '0; exp_rx = 0;
      repeat (3) @(negedge clk);
      // R9: reset values
      chk(tip == 0 && al == 0 && irq_flag == 0, "R9", "status at reset",
          {tip, al, irq_flag}, 0);
      chk(rx_byte == 0 && rx_ack == 0, "R9", "rx at reset", {rx_byte, rx_ack}, 0);
      chk(bc_req == 0, "R9", "bc_req at reset", bc_req, 0);
      rst_n = 1;
      cyc();
      core_en = 1; int_en = 1;
      cyc();
      // R1 R2 R4: START + write, slave acknowledges
      send(8'h90, 8'hA5, 8'h00, 0, 1);
      chk(irq == 1, "R7", "irq after completion", irq, 1);
      // R7: interrupt clear
      cmd_now = 8'h01; cyc(); cyc();
      chk(irq_flag == 0, "R7", "flag after clear", irq_flag, 0);
      // R4: write alone, slave does not acknowledge
      send(8'h10, 8'h3C, 8'h00, 1, 2);
      chk(rx_ack == 1, "R4", "nack sampled", rx_ack, 1);
      // R5: read with NACK driven, then STOP
      send(8'h68, 8'h00, 8'hC3, 0, 3);
      chk(rx_byte == 8'hC3, "R5", "read byte", rx_byte, 8'hC3);
      // R5: START + read with ACK driven
      send(8'hA0, 8'h00, 8'h5A, 0, 1);
      chk(rx_byte == 8'h5A, "R5", "read byte", rx_byte, 8'h5A);
      // R2: WRITE wins over READ
      send(8'h30, 8'h81, 8'hFF, 0, 2);
      chk(rx_byte == 8'h5A, "R2", "read not run", rx_byte, 8'h5A);
      // R2: START, write, STOP in one word
      send(8'hD0, 8'h7E, 8'h00, 0, 1);
      // R2: lone START and lone STOP
      send(8'h80, 8'h00, 8'h00, 0, 1);
      send(8'h40, 8'h00, 8'h00, 0, 2);
      // R1: command word while busy is ignored
      cmd_now = 8'h90; tx_now = 8'h0F; sack_now = 0; dly_now = 1;
      cyc();
      repeat (5) cyc();
      cmd_now = 8'h20;
      cyc();
      for (int i = 0; i < 400 && exp_tip; i++) cyc();
      chk(tip == 0 && q_op.size() == 0, "R1", "busy word ignored", tip, 0);
      cyc();
      // R7: irq masked by int_en
      int_en = 0;
      cyc();
      chk(irq == 0 && irq_flag == 1, "R7", "masked irq", {irq, irq_flag}, 2'b01);
      int_en = 1;
      // R8: disabled core ignores commands and the clear
      core_en = 0;
      cyc();
      cmd_now = 8'h91;
      cyc();
      repeat (4) cyc();
      chk(tip == 0 && irq_flag == 1, "R8", "disabled ignores", {tip, irq_flag}, 2'b01);
      core_en = 1;
      cyc();
      // R6: arbitration loss in the middle of the write byte
      cmd_now = 8'h90; tx_now = 8'hF0; dly_now = 2;
      cyc();
      repeat (7) cyc();
      arb_now = 1;
      cyc();
      repeat (4) cyc();
      chk(al == 1 && tip == 0, "R6", "abort state", {al, tip}, 2'b10);
      // R6: next accepted command clears al
      send(8'h40, 8'h00, 8'h00, 0, 1);
      chk(al == 0, "R6", "al cleared", al, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule